// File: doc/BRIEF.md
# Bus Release Controller

This block decides, cycle by cycle, whether the processor drives its external buses or gives them up to another bus master. Three independent sources can release the bus. The first is a halt request that is taken at an instruction boundary. The second is the wait state that the core enters on its own. The third is a direct three-state override. The block combines these sources with the core's bus cycle information and an external data-bus enable. From them it produces separate output enables for the address group, the read/write line and the data group, plus the valid-memory-address strobe, the read/write level and a bus-available flag.

The enables are meant for a top-level wrapper, which turns them into tri-state pads. The block also gives the core a wake-up pulse: while the core is waiting, an unmasked maskable interrupt or a non-maskable interrupt ends the wait.

Top module: `bus_release_ctrl`

## Requirements
- R1: While reset is held and right after it, `bus_avail` is 0, `addr_oe` and `rw_oe` are 1 (with `tsc` low), and `rw_out` is 1 when no write is requested.
- R2: A low `halt_n` without `insn_boundary` high at the same clock edge leaves `bus_avail` at 0 and the drivers enabled.
- R3: If `halt_n` is low and `insn_boundary` is high at a clock edge, `bus_avail` is 1 after that edge. It stays 1 for as long as `halt_n` stays low, regardless of `insn_boundary`.
- R4: At the first clock edge where `halt_n` is high again, a halted controller returns to normal operation, and `bus_avail` is 0 after that edge.
- R5: A one-cycle `wait_enter` pulse from the core puts the block in the wait state, and `bus_avail` is 1 after that edge.
- R6: In the wait state, `wake` is 1 in the same cycle as `nmi`, or as `irq` with `irq_mask` at 0, and `bus_avail` is 0 after the next edge. An `irq` with `irq_mask` at 1 leaves `wake` at 0 and the wait state unchanged.
- R7: While `bus_avail` is 1, `addr_oe`, `rw_oe`, `data_oe` and `vma` are 0 and `rw_out` is 1.
- R8: While `tsc` is 1, `addr_oe`, `rw_oe`, `vma` and `bus_avail` are 0 in the same cycle.
- R9: `data_oe` is 1 only when `dbe` is 1 and `core_write` is 1 (a write cycle) and the bus is not released. A read cycle (`core_write` 0) always gives `data_oe` 0.
- R10: `rw_out` is 0 (write) only when `core_write` is 1 and the bus is not released. Otherwise it is 1 (read).
- R11: If `tsc` is 1 while a halt is in effect, the three-state rule decides: `bus_avail` is 0 and the address and read/write enables are 0. Once `tsc` falls with the halt still held, `bus_avail` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| halt_n | input | 1 | Halt request, active low |
| insn_boundary | input | 1 | Core is at an instruction boundary this cycle |
| wait_enter | input | 1 | One-cycle pulse: core enters the wait state |
| irq | input | 1 | Maskable interrupt request |
| irq_mask | input | 1 | Interrupt mask bit from the core |
| nmi | input | 1 | Non-maskable interrupt event |
| tsc | input | 1 | Three-state override for the address and read/write groups |
| dbe | input | 1 | External data-bus drive enable |
| core_write | input | 1 | Core requests a write cycle (0 means read) |
| core_vma | input | 1 | Core reports a valid memory address |
| bus_avail | output | 1 | Bus released to another master |
| addr_oe | output | 1 | Address group output enable |
| rw_oe | output | 1 | Read/write line output enable |
| data_oe | output | 1 | Data group output enable |
| vma | output | 1 | Valid-memory-address strobe |
| rw_out | output | 1 | Read/write level: 1 read, 0 write |
| wake | output | 1 | Wake-up to the core out of the wait state |

## Verification
The bench builds the block with the default `HALT_AT_BOUNDARY` = 1, in which a halt request has to line up with an instruction boundary. This makes the deferred-halt case reachable: a low `halt_n` that meets no boundary is ignored. It also allows a halt that is held across several cycles with the boundary signal dropped. Both clock-edge timings of release are checked: entry after the boundary edge, and exit on the first edge after `halt_n` returns high. The same settings cover the overlaps between halt, wait and the three-state override.

// File: rtl/bus_release_pkg.sv
package bus_release_pkg;
  typedef enum logic {HS_RUN = 1'b0, HS_HALTED = 1'b1} halt_state_e;

  typedef struct packed {
    logic addr_oe;
    logic rw_oe;
    logic data_oe;
    logic vma;
    logic rw_out;
    logic bus_avail;
  } bus_drive_t;
endpackage

// File: rtl/brc_reset_sync.sv
module brc_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/brc_halt_track.sv
module brc_halt_track
  import bus_release_pkg::*;
#(
  parameter bit HALT_AT_BOUNDARY = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_n,
  input  logic insn_boundary,
  output logic halted
);
  halt_state_e state_q, state_d;
  logic        take_ok;
  logic        state_en;

  generate
    if (HALT_AT_BOUNDARY) begin : g_boundary
      assign take_ok = insn_boundary;
    end else begin : g_immediate
      assign take_ok = 1'b1;
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    case (state_q)
      HS_RUN:    if (!halt_n && take_ok) state_d = HS_HALTED;
      HS_HALTED: if (halt_n)             state_d = HS_RUN;
      default:   state_d = HS_RUN;
    endcase
  end

  assign state_en = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= HS_RUN;
    else if (state_en) state_q <= state_d;
  end

  assign halted = (state_q == HS_HALTED);
endmodule

// File: rtl/brc_wait_track.sv
module brc_wait_track (
  input  logic clk,
  input  logic rst_n,
  input  logic wait_enter,
  input  logic irq,
  input  logic irq_mask,
  input  logic nmi,
  output logic waiting,
  output logic wake
);
  logic wait_q, wait_d, wait_en;

  assign wake = wait_q && (nmi || (irq && !irq_mask));

  always_comb begin
    wait_d = wait_q;
    if (wake)            wait_d = 1'b0;
    else if (wait_enter) wait_d = 1'b1;
  end

  assign wait_en = (wait_d != wait_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wait_q <= 1'b0;
    else if (wait_en) wait_q <= wait_d;
  end

  assign waiting = wait_q;
endmodule

// File: rtl/brc_drive_gate.sv
module brc_drive_gate
  import bus_release_pkg::*;
(
  input  logic       released,
  input  logic       tsc,
  input  logic       dbe,
  input  logic       core_write,
  input  logic       core_vma,
  output bus_drive_t drive
);
  logic active;

  assign active = !released;

  always_comb begin
    drive.bus_avail = released && !tsc;
    drive.addr_oe   = active && !tsc;
    drive.rw_oe     = active && !tsc;
    drive.data_oe   = active && dbe && core_write;
    drive.vma       = active && !tsc && core_vma;
    drive.rw_out    = !(active && core_write);
  end
endmodule

// File: rtl/bus_release_ctrl.sv
module bus_release_ctrl
  import bus_release_pkg::*;
#(
  parameter bit HALT_AT_BOUNDARY = 1'b1,
  parameter int RST_STAGES       = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_n,
  input  logic insn_boundary,
  input  logic wait_enter,
  input  logic irq,
  input  logic irq_mask,
  input  logic nmi,
  input  logic tsc,
  input  logic dbe,
  input  logic core_write,
  input  logic core_vma,
  output logic bus_avail,
  output logic addr_oe,
  output logic rw_oe,
  output logic data_oe,
  output logic vma,
  output logic rw_out,
  output logic wake
);
  logic       rst_int_n;
  logic       halted;
  logic       waiting;
  bus_drive_t drive;

  brc_reset_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  brc_halt_track #(.HALT_AT_BOUNDARY(HALT_AT_BOUNDARY)) u_halt (
    .clk(clk), .rst_n(rst_int_n), .halt_n(halt_n),
    .insn_boundary(insn_boundary), .halted(halted)
  );

  brc_wait_track u_wait (
    .clk(clk), .rst_n(rst_int_n), .wait_enter(wait_enter),
    .irq(irq), .irq_mask(irq_mask), .nmi(nmi),
    .waiting(waiting), .wake(wake)
  );

  brc_drive_gate u_gate (
    .released(halted || waiting), .tsc(tsc), .dbe(dbe),
    .core_write(core_write), .core_vma(core_vma), .drive(drive)
  );

  assign bus_avail = drive.bus_avail;
  assign addr_oe   = drive.addr_oe;
  assign rw_oe     = drive.rw_oe;
  assign data_oe   = drive.data_oe;
  assign vma       = drive.vma;
  assign rw_out    = drive.rw_out;
endmodule

// File: rtl/bus_release_ctrl_chk.sv
module bus_release_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic halt_n,
  input logic insn_boundary,
  input logic wait_enter,
  input logic tsc,
  input logic dbe,
  input logic core_write,
  input logic bus_avail,
  input logic addr_oe,
  input logic rw_oe,
  input logic data_oe,
  input logic vma,
  input logic rw_out
);
  AST_RELEASED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    bus_avail |-> (!addr_oe && !rw_oe && !data_oe && !vma && rw_out)); // R7
  AST_TSC_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    tsc |-> (!addr_oe && !rw_oe && !vma && !bus_avail)); // R8
  AST_READ_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_write || !dbe) |-> !data_oe); // R9
  AST_RW_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !core_write |-> rw_out); // R10
  AST_RELEASE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tsc && $past(!tsc) && bus_avail && !$past(bus_avail))
      |-> ($past(!halt_n && insn_boundary) || $past(wait_enter))); // R2
endmodule

bind bus_release_ctrl bus_release_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .halt_n(halt_n), .insn_boundary(insn_boundary),
  .wait_enter(wait_enter), .tsc(tsc), .dbe(dbe), .core_write(core_write),
  .bus_avail(bus_avail), .addr_oe(addr_oe), .rw_oe(rw_oe),
  .data_oe(data_oe), .vma(vma), .rw_out(rw_out)
);

// File: tb/tb_bus_release_ctrl.sv
module tb_bus_release_ctrl;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n;
  logic halt_n, insn_boundary, wait_enter, irq, irq_mask, nmi;
  logic tsc, dbe, core_write, core_vma;
  logic bus_avail, addr_oe, rw_oe, data_oe, vma, rw_out, wake;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_release_ctrl dut (
    .clk(clk), .rst_n(rst_n), .halt_n(halt_n), .insn_boundary(insn_boundary),
    .wait_enter(wait_enter), .irq(irq), .irq_mask(irq_mask), .nmi(nmi),
    .tsc(tsc), .dbe(dbe), .core_write(core_write), .core_vma(core_vma),
    .bus_avail(bus_avail), .addr_oe(addr_oe), .rw_oe(rw_oe),
    .data_oe(data_oe), .vma(vma), .rw_out(rw_out), .wake(wake)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // advance one edge, then sample away from it
  task automatic step();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic idle_inputs();
    halt_n = 1'b1; insn_boundary = 1'b0; wait_enter = 1'b0;
    irq = 1'b0; irq_mask = 1'b1; nmi = 1'b0;
    tsc = 1'b0; dbe = 1'b0; core_write = 1'b0; core_vma = 1'b1;
  endtask

  task automatic t_reset();
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) step();
    chk("R1 bus_avail in reset", bus_avail, 1'b0);
    rst_n = 1'b1;
    repeat (4) step();
    chk("R1 bus_avail", bus_avail, 1'b0);
    chk("R1 addr_oe", addr_oe, 1'b1);
    chk("R1 rw_oe", rw_oe, 1'b1);
    chk("R1 rw_out", rw_out, 1'b1);
  endtask

  task automatic t_data();
    core_write = 1'b1; dbe = 1'b1; #1;
    chk("R9 write with dbe", data_oe, 1'b1);
    chk("R10 write level", rw_out, 1'b0);
    dbe = 1'b0; #1;
    chk("R9 dbe low", data_oe, 1'b0);
    core_write = 1'b0; dbe = 1'b1; #1;
    chk("R9 read cycle", data_oe, 1'b0);
    chk("R10 read level", rw_out, 1'b1);
    dbe = 1'b0;
    step();
  endtask

  task automatic t_halt();
    halt_n = 1'b0; insn_boundary = 1'b0;
    step(); step();
    chk("R2 no boundary bus_avail", bus_avail, 1'b0);
    chk("R2 no boundary addr_oe", addr_oe, 1'b1);
    insn_boundary = 1'b1;
    step();
    chk("R3 halt taken", bus_avail, 1'b1);
    insn_boundary = 1'b0;
    step(); step();
    chk("R3 halt held", bus_avail, 1'b1);
    core_write = 1'b1; dbe = 1'b1; core_vma = 1'b1; #1;
    chk("R7 addr_oe", addr_oe, 1'b0);
    chk("R7 rw_oe", rw_oe, 1'b0);
    chk("R7 data_oe", data_oe, 1'b0);
    chk("R7 vma", vma, 1'b0);
    chk("R7 rw_out", rw_out, 1'b1);
    chk("R10 released write level", rw_out, 1'b1);
    core_write = 1'b0; dbe = 1'b0;
    halt_n = 1'b1; #1;
    chk("R4 before edge", bus_avail, 1'b1);
    step();
    chk("R4 resumed", bus_avail, 1'b0);
    chk("R4 addr_oe", addr_oe, 1'b1);
  endtask

  task automatic t_wait();
    wait_enter = 1'b1;
    step();
    wait_enter = 1'b0;
    chk("R5 wait entered", bus_avail, 1'b1);
    irq = 1'b1; irq_mask = 1'b1; #1;
    chk("R6 masked irq wake", wake, 1'b0);
    step();
    chk("R6 masked irq stays", bus_avail, 1'b1);
    irq_mask = 1'b0; #1;
    chk("R6 irq wake", wake, 1'b1);
    step();
    irq = 1'b0; irq_mask = 1'b1;
    chk("R6 irq resumed", bus_avail, 1'b0);
    wait_enter = 1'b1;
    step();
    wait_enter = 1'b0;
    chk("R5 wait again", bus_avail, 1'b1);
    nmi = 1'b1; #1;
    chk("R6 nmi wake", wake, 1'b1);
    step();
    nmi = 1'b0;
    chk("R6 nmi resumed", bus_avail, 1'b0);
  endtask

  task automatic t_tsc();
    tsc = 1'b1; core_vma = 1'b1; #1;
    chk("R8 addr_oe", addr_oe, 1'b0);
    chk("R8 rw_oe", rw_oe, 1'b0);
    chk("R8 vma", vma, 1'b0);
    chk("R8 bus_avail", bus_avail, 1'b0);
    halt_n = 1'b0; insn_boundary = 1'b1;
    step();
    insn_boundary = 1'b0;
    step();
    chk("R11 bus_avail low", bus_avail, 1'b0);
    chk("R11 addr_oe", addr_oe, 1'b0);
    tsc = 1'b0; #1;
    chk("R11 after tsc", bus_avail, 1'b1);
    halt_n = 1'b1;
    step();
    chk("R4 resumed after tsc", bus_avail, 1'b0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_data();
        t_halt();
        t_wait();
        t_tsc();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule